// File: doc/BRIEF.md
# Dual-Lane Serial Converter Output Model

This block is a synthesizable stand-in for the digital side of a two-converter, two-channel serial sampling device. A host controller built for that kind of device can be exercised against it. A fast system clock samples everything: the slow converter clock, the convert-start strobe, the channel-select bit and the active-low chip select. The model decides which rising edge of the converter clock begins each conversion. It holds BUSY high through the sixteen converter-clock cycles of the conversion and shifts a 16-bit tagged frame out on two serial lines at once.

Sample values are not produced by any analog circuit. Two parallel words per converter lane, one for each input channel, are captured when the start strobe rises. That moment stands for the switch from sample mode to hold mode. The captured pair becomes the payload of the frames sent during the following conversion, which matches the pipelined result delivery of such devices. Timing windows are counted in system-clock ticks. A strobe that lands too close to a converter-clock edge is always deferred to the later edge, so the outcome is deterministic.

Top module: `adc_frame_model`

## Requirements
- R1: A conversion starts on the first converter-clock rising edge that is seen more than PRE_TICKS (default 2) system ticks after the system tick in which the start strobe's rising edge is seen. An edge that is exactly PRE_TICKS ticks after the strobe, or fewer, is skipped and the next edge is used.
- R2: A strobe rise seen in the same tick as a converter-clock rise, or within PRE_TICKS ticks after one, starts the conversion one full converter-clock period later than that edge.
- R3: busy rises in the tick after the strobe rise is seen, with no wait for the converter clock. It stays high until the 17th converter-clock rising edge, counting the start edge as the first, and is low from that edge on.
- R4: On the strobe rise, both lanes capture the sample word of the channel currently held by the channel latch: smp_a1/smp_b1 when it is 1, and smp_a0/smp_b0 when it is 0.
- R5: chan_sel is latched only on the first converter-clock falling edge after the start edge. At all other times it has no effect. The latched value selects the channel for the next strobe.
- R6: Frame bit 15 is the channel flag (1 = channel 1). Bit 14 is the lane flag, 0 on sdo_a and 1 on sdo_b. Bits 13:2 are the 12 data bits with the MSB at bit 13. Bits 1:0 are zero. Bit 15 is driven from the start edge, and each later converter-clock rising edge of the conversion moves on one bit toward bit 0.
- R7: The frame sent during a conversion carries the channel flag and samples captured at the previous strobe. The first conversion after reset sends channel 0 with all-zero data. Between conversions the lines carry 0.
- R8: While cs_n is high, sdo_a and sdo_b are 0. While cs_n is low, they show the current frame bit.
- R9: A strobe rise seen while a conversion is pending or running is ignored. It does not change busy, the frames or the timing.
- R10: After reset, busy, sdo_a and sdo_b are 0 and the channel latch holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk | input | 1 | External converter clock, sampled by clk |
| conv_start | input | 1 | Convert-start strobe, acts on its rising edge |
| chan_sel | input | 1 | Channel address for the next conversion |
| cs_n | input | 1 | Active-low enable for the serial outputs |
| smp_a0 | input | 12 | Lane A sample, channel 0 |
| smp_a1 | input | 12 | Lane A sample, channel 1 |
| smp_b0 | input | 12 | Lane B sample, channel 0 |
| smp_b1 | input | 12 | Lane B sample, channel 1 |
| busy | output | 1 | High from start strobe to end of conversion |
| sdo_a | output | 1 | Lane A serial data |
| sdo_b | output | 1 | Lane B serial data |

## Verification
The hardest case to reach is a strobe that lands right at the deferral boundary. This means exactly PRE_TICKS ticks before an edge, on the edge itself, or one tick after it, and the only sign at the ports is where busy falls 128 ticks later. The bench sweeps the strobe's lead over every tick offset from 0 to 10 ticks before a converter-clock rise and predicts the start edge arithmetically. It also toggles chan_sel everywhere except the few ticks just before the latching fall, and re-pulses the strobe in mid-conversion, so a wrong latch point or a re-trigger shows up in the next frame's channel flag or in the busy timing.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } adcf_state_e;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/adcf_edge.sv
module adcf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/adcf_lane.sv
module adcf_lane #(
    parameter int DATA_W    = 12,
    parameter bit LANE_FLAG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              chan_flag,
    input  logic [DATA_W-1:0] sample,
    input  logic              cs_n,
    output logic              dout
);
    localparam int FRAME_W = DATA_W + 4;

    logic [FRAME_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = {chan_flag, LANE_FLAG, sample, 2'b00};
        else if (shift) sh_d = {sh_q[FRAME_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = ~cs_n & sh_q[FRAME_W-1];

    AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (sh_q[0] == 1'b0)) else $error("zero fill"); // R6
endmodule

// File: rtl/adc_frame_model.sv
module adc_frame_model #(
    parameter int DATA_W    = 12,
    parameter int PRE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_clk,
    input  logic              conv_start,
    input  logic              chan_sel,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] smp_a0,
    input  logic [DATA_W-1:0] smp_a1,
    input  logic [DATA_W-1:0] smp_b0,
    input  logic [DATA_W-1:0] smp_b1,
    output logic              busy,
    output logic              sdo_a,
    output logic              sdo_b
);
    import adcf_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int CYC_W   = $clog2(FRAME_W + 1);
    localparam int AGE_W   = $clog2(PRE_TICKS + 2);
    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(PRE_TICKS + 1);
    localparam logic [CYC_W-1:0] CYC_ONE  = CYC_W'(1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(FRAME_W);

    typedef struct packed {
        adcf_state_e                       st;
        logic [AGE_W-1:0]                  age;
        logic [CYC_W-1:0]                  cyc;
        logic                              busy;
        logic                              pend;
        logic                              cap_ch;
        logic [NUM_LANES-1:0][DATA_W-1:0]  cap;
        logic                              res_ch;
        logic [NUM_LANES-1:0][DATA_W-1:0]  res;
    } ctrl_t;

    ctrl_t d, q;

    logic cv_rise, cv_fall, ck_rise, ck_fall;
    logic unused_cv_fall;
    logic [AGE_W-1:0] age_n;
    logic start, load, shift;
    logic [NUM_LANES-1:0][DATA_W-1:0] in_ch0, in_ch1;
    logic [NUM_LANES-1:0] lane_out;

    adcf_edge u_start_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (conv_start),
        .rise (cv_rise),
        .fall (cv_fall)
    );

    adcf_edge u_clk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (conv_clk),
        .rise (ck_rise),
        .fall (ck_fall)
    );

    assign unused_cv_fall = cv_fall;

    assign in_ch0 = {smp_b0, smp_a0};
    assign in_ch1 = {smp_b1, smp_a1};

    always_comb begin
        age_n = (q.age == AGE_MAX) ? q.age : q.age + AGE_W'(1);
        start = (q.st == ST_WAIT) && ck_rise && (age_n == AGE_MAX);
        load  = start;
        shift = (q.st == ST_CONV) && ck_rise && (q.cyc != CYC_LAST);
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (cv_rise) begin
                    d.st     = ST_WAIT;
                    d.age    = '0;
                    d.busy   = 1'b1;
                    d.cap_ch = q.pend;
                    d.cap    = q.pend ? in_ch1 : in_ch0;
                end
            end
            ST_WAIT: begin
                d.age = age_n;
                if (start) begin
                    d.st  = ST_CONV;
                    d.cyc = CYC_ONE;
                end
            end
            ST_CONV: begin
                if (ck_fall && (q.cyc == CYC_ONE)) d.pend = chan_sel;
                if (ck_rise) begin
                    if (q.cyc == CYC_LAST) begin
                        d.st     = ST_IDLE;
                        d.busy   = 1'b0;
                        d.cyc    = '0;
                        d.res_ch = q.cap_ch;
                        d.res    = q.cap;
                    end else begin
                        d.cyc = q.cyc + CYC_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        adcf_lane #(
            .DATA_W   (DATA_W),
            .LANE_FLAG((g == 1) ? 1'b1 : 1'b0)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .shift    (shift),
            .chan_flag(q.res_ch),
            .sample   (q.res[g]),
            .cs_n     (cs_n),
            .dout     (lane_out[g])
        );
    end

    assign busy  = q.busy;
    assign sdo_a = lane_out[0];
    assign sdo_b = lane_out[1];

    AST_BUSY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_IDLE) && cv_rise) |=> busy) else $error("busy late"); // R3
    AST_START_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_CONV) |-> $past(ck_rise)) else $error("start off edge"); // R1
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past((q.st == ST_CONV) && (q.cyc == CYC_LAST))) else $error("busy end"); // R3
    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != ST_CONV) || (q.cyc != CYC_ONE)) |=> $stable(q.pend)) else $error("addr latch"); // R5
    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CONV) |-> ((q.cyc != '0) && (q.cyc <= CYC_LAST))) else $error("cyc range"); // R3
    AST_IGNORE_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_CONV) && (q.cyc != CYC_LAST) && cv_rise) |=> (q.st == ST_CONV)) else $error("retrig"); // R9
endmodule

// File: tb/adc_frame_model_tb.sv
module adc_frame_model_tb;
    localparam int DW  = 12;
    localparam int PRE = 2;
    localparam int PER = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_clk = 1'b0, conv_start = 1'b0, chan_sel = 1'b0, cs_n = 1'b1;
    logic [DW-1:0] smp_a0 = '0, smp_a1 = '0, smp_b0 = '0, smp_b1 = '0;
    logic busy, sdo_a, sdo_b;

    int k = 0;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic          pend_m = 1'b0;
    logic          res_ch = 1'b0;
    logic [DW-1:0] res_a = '0, res_b = '0;

    always #2.5 clk = ~clk;

    adc_frame_model #(.DATA_W(DW), .PRE_TICKS(PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_clk(conv_clk), .conv_start(conv_start),
        .chan_sel(chan_sel), .cs_n(cs_n), .smp_a0(smp_a0), .smp_a1(smp_a1),
        .smp_b0(smp_b0), .smp_b1(smp_b1), .busy(busy), .sdo_a(sdo_a), .sdo_b(sdo_b)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at tick %0d: got %b expected %b", req, k, act, exp);
        end
    endtask

    // conv_clk is high in phases 4..7 of each 8-tick period: rises at k%8==4
    task automatic step();
        conv_clk = ((k + 1) % PER) >= 4;
        @(posedge clk);
        #1;
        k++;
    endtask

    task automatic do_conv(input int lead, input logic adr, input int csmode, input bit retrig);
        int b, t, e, idx;
        logic cap_ch;
        logic [DW-1:0] cap_a, cap_b;
        logic [15:0] fr_a, fr_b;
        logic eb, ea, ebb;
        conv_start = 1'b0;
        b = k + 12;
        while ((b % PER) != 4) b++;
        t = b - lead;
        e = t + PRE + 1;
        while ((e % PER) != 4) e++;
        smp_a0 = DW'(lead * 301 + 17);
        smp_a1 = DW'(lead * 1187 + 2048 + csmode * 5);
        smp_b0 = DW'(4095 - lead * 211);
        smp_b1 = DW'(lead * 97 + 1365 + retrig * 3);
        cap_ch = pend_m;
        cap_a  = pend_m ? smp_a1 : smp_a0;   // R4
        cap_b  = pend_m ? smp_b1 : smp_b0;
        fr_a = {res_ch, 1'b0, res_a, 2'b00};
        fr_b = {res_ch, 1'b1, res_b, 2'b00};
        while (k < e + 130) begin
            int nx;
            nx = k + 1;
            conv_start = (nx >= t) && !(retrig && nx >= e + 40 && nx <= e + 43);
            chan_sel   = (nx >= e + 1 && nx <= e + 4) ? adr : ~adr;
            cs_n       = (csmode == 0) ? 1'b0 : (((nx / 3) % 2) == 1);
            step();
            // R1 R2 R3 R9: busy window follows the predicted start edge
            chk("R1/R2/R3/R9 busy", busy, (k >= t) && (k < e + 128));
            if (k >= e && k < e + 128) begin
                idx = 15 - (k - e) / PER;
                ea  = fr_a[idx];
                ebb = fr_b[idx];
            end else begin
                ea  = 1'b0;     // R7 idle lines
                ebb = 1'b0;
            end
            eb = ~cs_n;
            chk("R6/R7/R8 sdo_a", sdo_a, ea & eb);
            chk("R6/R7/R8 sdo_b", sdo_b, ebb & eb);
        end
        res_ch = cap_ch;
        res_a  = cap_a;
        res_b  = cap_b;
        pend_m = adr;           // R5
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 busy", busy, 1'b0);
        chk("R10 sdo_a", sdo_a, 1'b0);
        chk("R10 sdo_b", sdo_b, 1'b0);
        cs_n = 1'b0;
        for (int r = 0; r < 3; r++) begin
            step();
            chk("R10 idle sdo_a", sdo_a, 1'b0);
        end
        for (int rt = 0; rt < 2; rt++) begin
            for (int ld = 0; ld <= 10; ld++) begin
                for (int cm = 0; cm < 2; cm++) begin
                    do_conv(ld, logic'((ld + cm + rt) % 2), cm, bit'(rt));
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired at tick %0d", k);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule